// File: doc/BRIEF.md
# Per-Pin GPIO Source Multiplexer

This block manages a 16-pin general-purpose I/O bank split into two independent sides, a receive side and a transmit side. Each side has four 16-bit registers on a simple word-addressed register bus: a software output value, a direction mask, a source select and a debug select. For every pin set as an output, the pair of select bits chooses the pin's source: the software value, the automatic transmit/receive (ATR) value supplied by a separate controller, or one of two debug buses from the fabric.

Pads are modelled as an output value plus an output enable per pin, and the incoming pad level is sampled into a register. Reading a side's value register returns the driven level for output pins and the sampled pad level for input pins. The software drives writes and reads with one-cycle strobes; write data lands on the next clock edge and read data appears one edge after the read strobe.

Top module: `gpmux_bank`

## Requirements
- R1: After reset every register reads as zero, every output enable is low and every pad output is low.
- R2: A write strobe updates the addressed register on the next rising edge, and a read strobe returns that register on `bus_rdata` after the next rising edge. The word address is `{kind[1:0], side}` with side 0 = receive, 1 = transmit and kind 0 = value, 1 = direction, 2 = source select, 3 = debug select.
- R3: A direction bit of 1 asserts that pin's output enable; a direction bit of 0 deasserts it and forces its pad output low, so writing zero to a direction register turns every pin of that side into an input.
- R4: An output pin whose debug bit is 0 and select bit is 0 drives the side's software value bit.
- R5: An output pin whose debug bit is 0 and select bit is 1 drives the side's ATR input bit, following it without a clock delay.
- R6: An output pin whose debug bit is 1 and select bit is 0 drives debug bus 0 of its side.
- R7: An output pin whose debug bit is 1 and select bit is 1 drives debug bus 1 of its side.
- R8: A write to one side leaves every register, output and enable of the other side unchanged.
- R9: A read of a side's value register returns, per pin, the driven pad level when the pin is an output and the pad input sampled one edge earlier when it is an input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word address: bit 0 side, bits 2:1 register kind |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |
| atr_rx | input | 16 | ATR value for the receive side |
| atr_tx | input | 16 | ATR value for the transmit side |
| dbgbus0_rx | input | 16 | Debug bus 0, receive side |
| dbgbus1_rx | input | 16 | Debug bus 1, receive side |
| dbgbus0_tx | input | 16 | Debug bus 0, transmit side |
| dbgbus1_tx | input | 16 | Debug bus 1, transmit side |
| pad_in_rx | input | 16 | Pad input level, receive side |
| pad_in_tx | input | 16 | Pad input level, transmit side |
| pad_out_rx | output | 16 | Pad output value, receive side |
| pad_oe_rx | output | 16 | Pad output enable, receive side |
| pad_out_tx | output | 16 | Pad output value, transmit side |
| pad_oe_tx | output | 16 | Pad output enable, transmit side |

## Verification
The source-path assertions assume the ATR and debug inputs are settled at each rising edge, since the pad outputs follow them combinationally; the bench changes those inputs only at falling edges. The read-back assertion assumes the pad input is held between the sampling edge and the read, so the stimulus sets pad levels at least two cycles before reading a value register. Strobes are assumed to last one cycle each and never to overlap a write and a read to the same register, which every bus task in the bench respects.

// File: rtl/gpmux_pkg.sv
`timescale 1ns/1ps
package gpmux_pkg;

    localparam int GPM_W  = 16;
    localparam int GPM_AW = 3;

    typedef logic [GPM_W-1:0] word_t;

    localparam logic [1:0] KIND_IO  = 2'd0;
    localparam logic [1:0] KIND_DIR = 2'd1;
    localparam logic [1:0] KIND_SEL = 2'd2;
    localparam logic [1:0] KIND_DBG = 2'd3;

    typedef struct packed {
        word_t io;
        word_t dir;
        word_t sel;
        word_t dbg;
    } bank_regs_t;

    typedef struct packed {
        word_t [1:0] pad_q;
        word_t       rdata;
    } front_state_t;

    typedef enum logic [1:0] {
        SRC_SW   = 2'd0,
        SRC_ATR  = 2'd1,
        SRC_DBG0 = 2'd2,
        SRC_DBG1 = 2'd3
    } src_e;

    function automatic src_e pick_src(input logic dbg_bit, input logic sel_bit);
        case ({dbg_bit, sel_bit})
            2'b00:   return SRC_SW;
            2'b01:   return SRC_ATR;
            2'b10:   return SRC_DBG0;
            default: return SRC_DBG1;
        endcase
    endfunction

endpackage

// File: rtl/gpmux_src_mux.sv
`timescale 1ns/1ps
module gpmux_src_mux
    import gpmux_pkg::*;
#(
    parameter int WIDTH = GPM_W
) (
    input  logic [WIDTH-1:0] sel_i,
    input  logic [WIDTH-1:0] dbg_i,
    input  logic [WIDTH-1:0] sw_i,
    input  logic [WIDTH-1:0] atr_i,
    input  logic [WIDTH-1:0] bus0_i,
    input  logic [WIDTH-1:0] bus1_i,
    output logic [WIDTH-1:0] pick_o
);

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic bit_pick;
        always_comb begin
            case (pick_src(dbg_i[p], sel_i[p]))
                SRC_SW:   bit_pick = sw_i[p];
                SRC_ATR:  bit_pick = atr_i[p];
                SRC_DBG0: bit_pick = bus0_i[p];
                default:  bit_pick = bus1_i[p];
            endcase
        end
        assign pick_o[p] = bit_pick;
    end

endmodule

// File: rtl/gpmux_side.sv
`timescale 1ns/1ps
module gpmux_side
    import gpmux_pkg::*;
#(
    parameter int WIDTH = GPM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       kind_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] atr_i,
    input  logic [WIDTH-1:0] bus0_i,
    input  logic [WIDTH-1:0] bus1_i,
    output bank_regs_t       regs_o,
    output logic [WIDTH-1:0] pad_out_o,
    output logic [WIDTH-1:0] pad_oe_o
);

    bank_regs_t       regs_d;
    bank_regs_t       regs_q;
    logic [WIDTH-1:0] picked;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            case (kind_i)
                KIND_IO:  regs_d.io  = wdata_i;
                KIND_DIR: regs_d.dir = wdata_i;
                KIND_SEL: regs_d.sel = wdata_i;
                default:  regs_d.dbg = wdata_i;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    gpmux_src_mux #(.WIDTH(WIDTH)) u_mux (
        .sel_i  (regs_q.sel),
        .dbg_i  (regs_q.dbg),
        .sw_i   (regs_q.io),
        .atr_i  (atr_i),
        .bus0_i (bus0_i),
        .bus1_i (bus1_i),
        .pick_o (picked)
    );

    assign regs_o    = regs_q;
    assign pad_oe_o  = regs_q.dir;
    assign pad_out_o = picked & regs_q.dir;

    assert_io_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && kind_i == KIND_IO) |=> regs_o.io == $past(wdata_i));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(regs_o));

    assert_sw_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o.dir & ~regs_o.dbg & ~regs_o.sel & (pad_out_o ^ regs_o.io)) == '0);

    assert_atr_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o.dir & ~regs_o.dbg & regs_o.sel & (pad_out_o ^ atr_i)) == '0);

    assert_dbg0_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o.dir & regs_o.dbg & ~regs_o.sel & (pad_out_o ^ bus0_i)) == '0);

    assert_dbg1_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_o.dir & regs_o.dbg & regs_o.sel & (pad_out_o ^ bus1_i)) == '0);

endmodule

// File: rtl/gpmux_bank.sv
`timescale 1ns/1ps
module gpmux_bank
    import gpmux_pkg::*;
#(
    parameter int WIDTH = GPM_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPM_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  atr_rx,
    input  logic [WIDTH-1:0]  atr_tx,
    input  logic [WIDTH-1:0]  dbgbus0_rx,
    input  logic [WIDTH-1:0]  dbgbus1_rx,
    input  logic [WIDTH-1:0]  dbgbus0_tx,
    input  logic [WIDTH-1:0]  dbgbus1_tx,
    input  logic [WIDTH-1:0]  pad_in_rx,
    input  logic [WIDTH-1:0]  pad_in_tx,
    output logic [WIDTH-1:0]  pad_out_rx,
    output logic [WIDTH-1:0]  pad_oe_rx,
    output logic [WIDTH-1:0]  pad_out_tx,
    output logic [WIDTH-1:0]  pad_oe_tx
);

    localparam int NSIDE = 2;

    logic             side_sel;
    logic [1:0]       kind;
    word_t            atr_a  [NSIDE];
    word_t            bus0_a [NSIDE];
    word_t            bus1_a [NSIDE];
    word_t            out_a  [NSIDE];
    word_t            oe_a   [NSIDE];
    bank_regs_t       regs_a [NSIDE];
    front_state_t     state_d;
    front_state_t     state_q;

    assign side_sel = bus_addr[0];
    assign kind     = bus_addr[2:1];

    assign atr_a[0]  = atr_rx;
    assign atr_a[1]  = atr_tx;
    assign bus0_a[0] = dbgbus0_rx;
    assign bus0_a[1] = dbgbus0_tx;
    assign bus1_a[0] = dbgbus1_rx;
    assign bus1_a[1] = dbgbus1_tx;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        logic side_wr;
        assign side_wr = bus_wr && (side_sel == s[0]);

        gpmux_side #(.WIDTH(WIDTH)) u_side (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (side_wr),
            .kind_i    (kind),
            .wdata_i   (bus_wdata),
            .atr_i     (atr_a[s]),
            .bus0_i    (bus0_a[s]),
            .bus1_i    (bus1_a[s]),
            .regs_o    (regs_a[s]),
            .pad_out_o (out_a[s]),
            .pad_oe_o  (oe_a[s])
        );
    end

    assign pad_out_rx = out_a[0];
    assign pad_oe_rx  = oe_a[0];
    assign pad_out_tx = out_a[1];
    assign pad_oe_tx  = oe_a[1];

    always_comb begin
        state_d          = state_q;
        state_d.pad_q[0] = pad_in_rx;
        state_d.pad_q[1] = pad_in_tx;
        if (bus_rd) begin
            case (kind)
                KIND_IO:  state_d.rdata = (oe_a[side_sel] & out_a[side_sel])
                                        | (~oe_a[side_sel] & state_q.pad_q[side_sel]);
                KIND_DIR: state_d.rdata = regs_a[side_sel].dir;
                KIND_SEL: state_d.rdata = regs_a[side_sel].sel;
                default:  state_d.rdata = regs_a[side_sel].dbg;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_rdata = state_q.rdata;

    assert_oe_follows_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd2) |=> pad_oe_rx == $past(bus_wdata));

    assert_read_io_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd0) |=>
            bus_rdata == ($past(pad_out_rx & pad_oe_rx)
                        | ($past(~pad_oe_rx) & $past(state_q.pad_q[0]))));

    assert_rx_untouched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[0]) |=> $stable(pad_oe_rx));

endmodule

// File: tb/sim_gpmux_bank.sv
`timescale 1ns/1ps
module sim_gpmux_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic [15:0] atr_rx = '0, atr_tx = '0;
    logic [15:0] dbgbus0_rx = '0, dbgbus1_rx = '0, dbgbus0_tx = '0, dbgbus1_tx = '0;
    logic [15:0] pad_in_rx = '0, pad_in_tx = '0;
    logic [15:0] pad_out_rx, pad_oe_rx, pad_out_tx, pad_oe_tx;

    int errors = 0;
    int checks = 0;

    typedef struct {
        string       tag;
        logic [15:0] exp;
    } rd_item_t;

    rd_item_t exp_q[$];
    logic     rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    gpmux_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .atr_rx(atr_rx), .atr_tx(atr_tx),
        .dbgbus0_rx(dbgbus0_rx), .dbgbus1_rx(dbgbus1_rx),
        .dbgbus0_tx(dbgbus0_tx), .dbgbus1_tx(dbgbus1_tx),
        .pad_in_rx(pad_in_rx), .pad_in_tx(pad_in_tx),
        .pad_out_rx(pad_out_rx), .pad_oe_rx(pad_oe_rx),
        .pad_out_tx(pad_out_tx), .pad_oe_tx(pad_oe_tx)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        it.tag = tag; it.exp = exp;
        exp_q.push_back(it);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual=%h expected=none", bus_rdata);
            end else begin
                rd_item_t it;
                it = exp_q.pop_front();
                chk(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe_rx", pad_oe_rx, 16'h0000);
        chk("R1 oe_tx", pad_oe_tx, 16'h0000);
        chk("R1 out_rx", pad_out_rx, 16'h0000);
        chk("R1 out_tx", pad_out_tx, 16'h0000);
        for (int a = 0; a < 8; a++) rd(3'(a), 16'h0000, "R1 reg zero");

        // R4 software path, R3 enable
        wr(3'd2, 16'hFFFF);
        wr(3'd0, 16'hA5A5);
        chk("R3 oe_rx all", pad_oe_rx, 16'hFFFF);
        chk("R4 sw out_rx", pad_out_rx, 16'hA5A5);
        chk("R8 tx oe", pad_oe_tx, 16'h0000);

        // R5 ATR on low byte
        atr_rx = 16'h1234;
        wr(3'd4, 16'h00FF);
        chk("R5 atr mix", pad_out_rx, 16'hA534);

        // R6 R7 debug buses
        dbgbus0_rx = 16'hCCCC;
        dbgbus1_rx = 16'h3333;
        wr(3'd6, 16'h0F0F);
        chk("R6 R7 four-way mix", pad_out_rx, 16'hAC33);
        atr_rx = 16'h0000;
        #1;
        chk("R5 atr live", pad_out_rx, 16'hAC03);
        atr_rx = 16'h1234;

        // R3 partial direction, R9 mixed read
        wr(3'd2, 16'h00F0);
        chk("R3 oe partial", pad_oe_rx, 16'h00F0);
        chk("R3 out masked", pad_out_rx, 16'h0030);
        pad_in_rx = 16'h5A5A;
        repeat (2) @(negedge clk);
        rd(3'd0, 16'h5A3A, "R9 rx io mixed");
        rd(3'd6, 16'h0F0F, "R2 rx dbg readback");

        // transmit side, R8 isolation
        wr(3'd3, 16'hFFFF);
        wr(3'd1, 16'h0F0F);
        chk("R4 tx sw", pad_out_tx, 16'h0F0F);
        atr_tx = 16'hBEEF;
        wr(3'd5, 16'hFFFF);
        chk("R5 tx atr", pad_out_tx, 16'hBEEF);
        chk("R8 rx out kept", pad_out_rx, 16'h0030);
        chk("R8 rx oe kept", pad_oe_rx, 16'h00F0);
        rd(3'd5, 16'hFFFF, "R2 tx sel readback");
        rd(3'd1, 16'hBEEF, "R9 tx io driven");
        dbgbus1_tx = 16'h7E57;
        dbgbus0_tx = 16'h1DEA;
        wr(3'd7, 16'hFFFF);
        chk("R7 tx bus1", pad_out_tx, 16'h7E57);
        wr(3'd5, 16'h0000);
        chk("R6 tx bus0", pad_out_tx, 16'h1DEA);
        rd(3'd4, 16'h00FF, "R8 rx sel kept");

        // R3 all inputs
        wr(3'd2, 16'h0000);
        wr(3'd3, 16'h0000);
        chk("R3 oe_rx off", pad_oe_rx, 16'h0000);
        chk("R3 oe_tx off", pad_oe_tx, 16'h0000);
        chk("R3 out_tx low", pad_out_tx, 16'h0000);
        pad_in_tx = 16'h6C6C;
        repeat (2) @(negedge clk);
        rd(3'd1, 16'h6C6C, "R9 tx io input");
        rd(3'd0, 16'h5A5A, "R9 rx io input");
        rd(3'd2, 16'h0000, "R2 rx dir readback");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule